// File: doc/BRIEF.md
# Outbound Request Retry Tracker

This block sits between a queue of outbound read or write requests and a bus master that drives a PCI-like target bus. Each accepted request occupies one of a few slots. A slot holds a start address in bytes, a remaining doubleword count and a retry timer. A slot that is ready to go is offered to the bus master with its slot number as a tag. The master later reports one of three outcomes for that tag: completed, retried, or disconnected after some number of words.

A retry puts the slot back in line unchanged. A disconnect moves the slot's address forward and reduces its count by the words already moved, so the next attempt resumes at the first untransferred word. The master reports a disconnect only once the data of that attempt has finished moving. Slots are served round-robin, so attempts of different requests interleave, and requests can complete in any order.

Each slot's timer starts at the first issue of its request. A request still waiting for a reissue after `TMO_CYCLES` cycles is dropped. It is then reported on the completion port with an error flag.

Top module: `retry_tracker`

## Requirements
- R1: After reset, `req_ready` is 1, `iss_valid` is 0 and `cpl_valid` is 0.
- R2: An accepted request is placed in the lowest-numbered free slot. `req_ready` is 0 while all slots are occupied.
- R3: The first issue of a request carries its slot number, its address and its count exactly as accepted.
- R4: A result with `res_kind` = 2'b01 (retry) makes the slot eligible again with address and count unchanged.
- R5: A result with `res_kind` = 2'b10 (disconnect) and `res_words` = k makes the next issue carry address + 4k and count − k.
- R6: A slot that has been issued is not offered again until a result for that slot has been reported.
- R7: A result with `res_kind` = 2'b00 (done) gives `cpl_valid` = 1 one cycle later, with `cpl_slot` equal to that slot and `cpl_err` = 0. The slot is freed.
- R8: Eligible slots are granted round-robin, starting after the most recently granted slot.
- R9: A slot whose timer reaches `TMO_CYCLES` cycles since its first issue, while it waits for reissue, is not issued again. It is reported with `cpl_err` = 1 and freed. A done report in the same cycle takes precedence on the completion port.
- R10: Completions carry the slot tag and may occur in an order different from the issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request offered by the queue |
| req_ready | output | 1 | A free slot exists |
| req_addr | input | AW | Start byte address |
| req_count | input | CW | Doublewords requested (at least 1) |
| iss_valid | output | 1 | A slot is offered for a bus attempt |
| iss_ready | input | 1 | Bus master takes the offered attempt |
| iss_slot | output | SW | Tag of the offered slot |
| iss_addr | output | AW | Address of the attempt |
| iss_count | output | CW | Doublewords remaining |
| res_valid | input | 1 | Outcome of an attempt reported |
| res_slot | input | SW | Tag of the reported attempt |
| res_kind | input | 2 | 00 done, 01 retry, 10 disconnect |
| res_words | input | CW | Words moved before a disconnect |
| cpl_valid | output | 1 | Request finished |
| cpl_slot | output | SW | Tag of the finished request |
| cpl_err | output | 1 | 1 if the request ended by timeout |

## Verification
The bench builds the block with three slots and `TMO_CYCLES` = 40. With that limit, a request that keeps being retried reaches its timeout within a short directed test. The same limit is still long enough that the round-robin, disconnect and out-of-order scenarios finish before any timer expires. With three slots, the bench can fill the tracker completely and watch the grant order wrap around.

// File: rtl/retry_tracker.sv
module retry_tracker #(
  parameter int NSLOT = 3,
  parameter int AW = 32,
  parameter int CW = 8,
  parameter int TMO_CYCLES = 4096,
  parameter int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_count,
  output logic          iss_valid,
  input  logic          iss_ready,
  output logic [SW-1:0] iss_slot,
  output logic [AW-1:0] iss_addr,
  output logic [CW-1:0] iss_count,
  input  logic          res_valid,
  input  logic [SW-1:0] res_slot,
  input  logic [1:0]    res_kind,
  input  logic [CW-1:0] res_words,
  output logic          cpl_valid,
  output logic [SW-1:0] cpl_slot,
  output logic          cpl_err
);
  localparam int TW = $clog2(TMO_CYCLES + 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_WAIT = 2'd1, S_BUSY = 2'd2;
  localparam logic [1:0] K_DONE = 2'b00, K_RETRY = 2'b01, K_DISC = 2'b10;

  logic [NSLOT-1:0][1:0]    st_q;
  logic [NSLOT-1:0][AW-1:0] addr_q;
  logic [NSLOT-1:0][CW-1:0] cnt_q;
  logic [NSLOT-1:0][TW-1:0] tmr_q;
  logic [NSLOT-1:0]         run_q;
  logic [SW-1:0]            rr_q;

  logic [NSLOT-1:0] expd, elig;
  logic [SW-1:0]    alloc_sel, grant_sel, tmo_sel;
  logic             alloc_ok, grant_ok, tmo_ok;

  always_comb begin
    alloc_ok = 1'b0; alloc_sel = '0;
    tmo_ok = 1'b0; tmo_sel = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      expd[i] = run_q[i] && (tmr_q[i] == TW'(TMO_CYCLES));
      elig[i] = (st_q[i] == S_WAIT) && !expd[i];
      if (st_q[i] == S_IDLE) begin alloc_ok = 1'b1; alloc_sel = SW'(i); end
      if (st_q[i] == S_WAIT && expd[i]) begin tmo_ok = 1'b1; tmo_sel = SW'(i); end
    end
    grant_ok = 1'b0; grant_sel = '0;
    for (int k = 1; k <= NSLOT; k++) begin
      int j;
      j = (int'(rr_q) + k) % NSLOT;
      if (!grant_ok && elig[j]) begin grant_ok = 1'b1; grant_sel = SW'(j); end
    end
  end

  wire req_fire = req_valid && alloc_ok;
  wire iss_fire = grant_ok && iss_ready;
  wire done_in  = res_valid && res_kind == K_DONE;
  wire tmo_fire = tmo_ok && !done_in;

  assign req_ready = alloc_ok;
  assign iss_valid = grant_ok;
  assign iss_slot  = grant_sel;
  assign iss_addr  = addr_q[grant_sel];
  assign iss_count = cnt_q[grant_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0; addr_q <= '0; cnt_q <= '0; tmr_q <= '0; run_q <= '0;
      rr_q <= SW'(NSLOT - 1);
      cpl_valid <= 1'b0; cpl_slot <= '0; cpl_err <= 1'b0;
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (run_q[i] && !expd[i]) tmr_q[i] <= tmr_q[i] + 1'b1;
        if (req_fire && alloc_sel == SW'(i)) begin
          st_q[i] <= S_WAIT; addr_q[i] <= req_addr; cnt_q[i] <= req_count;
          run_q[i] <= 1'b0; tmr_q[i] <= '0;
        end
        if (iss_fire && grant_sel == SW'(i)) begin
          st_q[i] <= S_BUSY;
          if (!run_q[i]) begin run_q[i] <= 1'b1; tmr_q[i] <= '0; end
        end
        if (res_valid && res_slot == SW'(i) && st_q[i] == S_BUSY) begin
          case (res_kind)
            K_DONE:  begin st_q[i] <= S_IDLE; run_q[i] <= 1'b0; end
            K_DISC:  begin
              st_q[i] <= S_WAIT;
              addr_q[i] <= addr_q[i] + (AW'(res_words) << 2);
              cnt_q[i] <= cnt_q[i] - res_words;
            end
            default: st_q[i] <= S_WAIT;
          endcase
        end
        if (tmo_fire && tmo_sel == SW'(i)) begin
          st_q[i] <= S_IDLE; run_q[i] <= 1'b0;
        end
      end
      if (iss_fire) rr_q <= grant_sel;
      cpl_valid <= done_in || tmo_fire;
      cpl_slot  <= done_in ? res_slot : tmo_sel;
      cpl_err   <= !done_in && tmo_fire;
    end
  end
endmodule

// File: rtl/retry_tracker_chk.sv
module retry_tracker_chk #(
  parameter int NSLOT = 3,
  parameter int AW = 32,
  parameter int CW = 8,
  parameter int SW = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     iss_valid,
  input logic                     iss_ready,
  input logic [SW-1:0]            iss_slot,
  input logic                     res_valid,
  input logic [SW-1:0]            res_slot,
  input logic [1:0]               res_kind,
  input logic [CW-1:0]            res_words,
  input logic                     cpl_valid,
  input logic [SW-1:0]            cpl_slot,
  input logic                     cpl_err,
  input logic [NSLOT-1:0][AW-1:0] addr_q,
  input logic [NSLOT-1:0][CW-1:0] cnt_q
);
  // R6
  no_reoffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_ready |=> !(iss_valid && iss_slot == $past(iss_slot)));

  // R7
  done_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind == 2'b00 |=> cpl_valid && !cpl_err && cpl_slot == $past(res_slot));

  // R4
  retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind == 2'b01 && !(iss_valid && iss_ready)
    |=> addr_q[$past(res_slot)] == $past(addr_q[res_slot])
        && cnt_q[$past(res_slot)] == $past(cnt_q[res_slot]));

  // R5
  disc_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind == 2'b10
    |=> cnt_q[$past(res_slot)] == $past(cnt_q[res_slot]) - $past(res_words));

  // R10
  tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> int'(cpl_slot) < NSLOT);
endmodule

bind retry_tracker retry_tracker_chk #(.NSLOT(NSLOT), .AW(AW), .CW(CW), .SW(SW)) chk_i (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_slot(iss_slot), .res_valid(res_valid), .res_slot(res_slot),
  .res_kind(res_kind), .res_words(res_words), .cpl_valid(cpl_valid),
  .cpl_slot(cpl_slot), .cpl_err(cpl_err), .addr_q(addr_q), .cnt_q(cnt_q)
);

// File: tb/retry_tracker_tb_top.sv
module retry_tracker_tb_top;
  localparam int NSLOT = 3, AW = 32, CW = 8, TMO = 40, SW = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, iss_ready = 0, res_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_count = '0, res_words = '0;
  logic [SW-1:0] res_slot = '0;
  logic [1:0] res_kind = '0;
  logic req_ready, iss_valid, cpl_valid, cpl_err;
  logic [SW-1:0] iss_slot, cpl_slot;
  logic [AW-1:0] iss_addr;
  logic [CW-1:0] iss_count;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  retry_tracker #(.NSLOT(NSLOT), .AW(AW), .CW(CW), .TMO_CYCLES(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_count(req_count), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .iss_slot(iss_slot), .iss_addr(iss_addr),
    .iss_count(iss_count), .res_valid(res_valid), .res_slot(res_slot),
    .res_kind(res_kind), .res_words(res_words), .cpl_valid(cpl_valid),
    .cpl_slot(cpl_slot), .cpl_err(cpl_err));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [CW-1:0] c);
    @(negedge clk); req_valid = 1; req_addr = a; req_count = c;
    #1; while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk); req_valid = 0;
  endtask

  task automatic take(output int s, output logic [AW-1:0] a, output logic [CW-1:0] c);
    @(negedge clk); iss_ready = 1;
    #1; while (!iss_valid) begin @(negedge clk); #1; end
    s = int'(iss_slot); a = iss_addr; c = iss_count;
    @(posedge clk); @(negedge clk); iss_ready = 0;
  endtask

  task automatic resp(input int s, input logic [1:0] k, input int w,
                      output logic v, output int cs, output logic ce);
    @(negedge clk); res_valid = 1; res_slot = SW'(s); res_kind = k; res_words = CW'(w);
    @(posedge clk); @(negedge clk); res_valid = 0;
    #1; v = cpl_valid; cs = int'(cpl_slot); ce = cpl_err;
  endtask

  task automatic t_reset();
    #1;
    chk(req_ready === 1, "R1 req_ready", req_ready, 1);
    chk(iss_valid === 0, "R1 iss_valid", iss_valid, 0);
    chk(cpl_valid === 0, "R1 cpl_valid", cpl_valid, 0);
  endtask

  task automatic t_simple();
    int s, cs; logic [AW-1:0] a; logic [CW-1:0] c; logic v, ce;
    push(32'h100, 4);
    take(s, a, c);
    chk(s == 0, "R2 lowest slot", s, 0);
    chk(a == 32'h100 && c == 4, "R3 first issue", {a, c}, {32'h100, 8'd4});
    resp(s, 2'b00, 0, v, cs, ce);
    chk(v && cs == 0 && !ce, "R7 done completion", {v, cs[1:0], ce}, 4'b1000);
  endtask

  task automatic t_retry_disc();
    int s, s2, cs; logic [AW-1:0] a; logic [CW-1:0] c; logic v, ce;
    push(32'h200, 8);
    take(s, a, c);
    #1; chk(!(iss_valid && int'(iss_slot) == s), "R6 no reoffer while busy", iss_valid, 0);
    resp(s, 2'b01, 5, v, cs, ce);
    take(s2, a, c);
    chk(s2 == s && a == 32'h200 && c == 8, "R4 retry unchanged", {a, c}, {32'h200, 8'd8});
    resp(s, 2'b10, 3, v, cs, ce);
    chk(!v, "R5 no completion on disconnect", v, 0);
    take(s2, a, c);
    chk(a == 32'h20C && c == 5, "R5 resume point", {a, c}, {32'h20C, 8'd5});
    resp(s, 2'b10, 4, v, cs, ce);
    take(s2, a, c);
    chk(a == 32'h21C && c == 1, "R5 second disconnect", {a, c}, {32'h21C, 8'd1});
    resp(s, 2'b00, 0, v, cs, ce);
    chk(v && cs == s && !ce, "R7 done after resume", cs, s);
  endtask

  task automatic t_full_rr();
    int g[6]; int cs; logic [AW-1:0] a; logic [CW-1:0] c; logic v, ce;
    push(32'h1000, 2); push(32'h2000, 2); push(32'h3000, 2);
    #1; chk(req_ready === 0, "R2 full blocks", req_ready, 0);
    for (int i = 0; i < 3; i++) take(g[i], a, c);
    chk(g[0] != g[1] && g[1] != g[2] && g[0] != g[2], "R8 distinct grants", g[2], 3 - g[0] - g[1]);
    for (int i = 0; i < 3; i++) resp(g[i], 2'b01, 0, v, cs, ce);
    for (int i = 3; i < 6; i++) take(g[i], a, c);
    for (int i = 3; i < 6; i++)
      chk(g[i] == (g[2] + i - 2) % 3, "R8 round robin order", g[i], (g[2] + i - 2) % 3);
    resp(g[4], 2'b00, 0, v, cs, ce);
    chk(v && cs == g[4], "R10 out of order completion", cs, g[4]);
    resp(g[3], 2'b00, 0, v, cs, ce);
    chk(v && cs == g[3], "R10 second completion", cs, g[3]);
    resp(g[5], 2'b00, 0, v, cs, ce);
    chk(v && cs == g[5], "R10 last completion", cs, g[5]);
  endtask

  task automatic t_timeout();
    int s, cs, n; logic [AW-1:0] a; logic [CW-1:0] c; logic v, ce;
    push(32'h4000, 6);
    take(s, a, c);
    resp(s, 2'b01, 0, v, cs, ce);
    n = 0;
    while (!cpl_valid && n < 200) begin @(negedge clk); #1; n++; end
    chk(cpl_valid && int'(cpl_slot) == s && cpl_err, "R9 timeout report",
        {cpl_valid, cpl_slot, cpl_err}, {1'b1, SW'(s), 1'b1});
    chk(n >= 30 && n <= 45, "R9 timeout latency", n, 38);
    @(negedge clk); #1;
    chk(!iss_valid && req_ready, "R9 slot freed not reissued", {iss_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_simple();
    t_retry_disc();
    t_full_rr();
    t_timeout();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule